// File: doc/BRIEF.md
# UART Register Front End with Receive and Transmit Queues

This block is the register side of a simple serial port. A processor reaches four word registers through a small synchronous write port and a combinational read port. Behind those registers sit a 16-entry receive queue and a 16-entry transmit queue. A byte-level engine, outside this block, shifts bytes on and off the line. That engine takes transmit bytes with a valid/take handshake and delivers receive bytes with a one-cycle strobe.

Software moves bytes through a single data register. Handshake flags in that register say whether a received byte is waiting and whether the transmit queue has room. Writing the data register with a flag set pops a received byte or pushes a transmit byte. Reading the data register has no side effect.

Three interrupt sources raise sticky status bits: receive data arrived, transmit queue running low, and receive overrun. Software clears each bit by writing one to it. Each source has its own enable bit. A master host enable gates the combined interrupt line.

Top module: `uart_regif`

## Requirements
- R1: Register 0 (data) reads the oldest received byte in bits 7:0 and a receive-ready flag in bit 8 that is 1 when the receive queue holds data. Bits 7:0 read 0 when that queue is empty. Reading does not remove the byte.
- R2: Writing register 0 with bit 8 set pops one receive entry. Such a write is ignored when the receive queue is empty.
- R3: Register 0 bit 9 reads 1 when the transmit queue has room. Writing register 0 with bit 9 set pushes bits 7:0 into the transmit queue. A push to a full queue is ignored.
- R4: The transmit queue presents its oldest byte on `txByte` with `txValid` high while it is non-empty. A cycle with `txValid` and `txTake` both high removes that byte. Bytes leave in push order.
- R5: Register 1 bit 1 (busy) reads 1 while the transmit queue is non-empty or `txShiftBusy` is high.
- R6: Register 1 bit 0 is the host interrupt enable (read/write). While it is 0, `irq` stays low whatever is pending.
- R7: `irq` is high exactly when the host enable is 1 and some status bit in register 2 has its enable bit set in register 3. Writing 0 to register 3 disables every source.
- R8: Register 2 status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over a clear.
- R9: Status bit 0 (receive data) sets when the receive queue goes from empty to non-empty.
- R10: Status bit 1 (transmit low) sets when the transmit queue count falls from above 2 to 2 or fewer. It does not set at reset.
- R11: Status bit 2 (overrun) sets when a receive strobe arrives while the receive queue is full. That byte is dropped.
- R12: Each queue holds exactly 16 entries and keeps first-in first-out order.
- R13: After reset, both queues are empty, every status, enable and control bit is 0, `irq` is low, and register 0 reads 0x200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select (0 data, 1 control, 2 status, 3 enable) |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data of the selected register |
| irq | output | 1 | Interrupt request |
| txValid | output | 1 | Transmit byte available to the engine |
| txByte | output | 8 | Oldest transmit byte |
| txTake | input | 1 | Engine takes the presented byte |
| txShiftBusy | input | 1 | Engine shifter still sending |
| rxStrobe | input | 1 | Engine delivers a received byte this cycle |
| rxByte | input | 8 | Received byte |

## Verification
The bench reads the data register twice in a row. A design that popped on read would show the second byte instead of the first. It pops an empty receive queue and then checks that the next byte still arrives intact, which catches pointer underflow. It fills each queue to 16 and then offers one more byte. A design with the wrong depth or an unguarded full check would accept the 17th byte, and that byte would show up when the queue is drained. The bench watches the low-water status across the step from three entries to two. It also checks that a clear written as 0 leaves the other sticky bits alone, and that the interrupt line stays low while the host enable is off.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_SRC = 3;

  // interrupt source bit positions in the status and enable registers
  localparam int SRC_RX    = 0;
  localparam int SRC_TXLOW = 1;
  localparam int SRC_OVR   = 2;

  // handshake flag positions in the data register
  localparam int FLAG_RX = 8;
  localparam int FLAG_TX = 9;

  typedef enum logic [1:0] {
    REG_DATA   = 2'd0,
    REG_CTRL   = 2'd1,
    REG_STAT   = 2'd2,
    REG_ENABLE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic popRx;
    logic pushTx;
    logic wrCtrl;
    logic wrIntClr;
    logic wrIntEn;
  } regStrobe_t;

  typedef struct packed {
    logic [BYTE_W-1:0]  rxHead;
    logic               rxAvail;
    logic               txSpace;
    logic               txBusy;
    logic               hostEn;
    logic [NUM_SRC-1:0] intStat;
    logic [NUM_SRC-1:0] intEn;
  } regView_t;
endpackage

// File: rtl/uart_regif_fifo.sv
module uart_regif_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;
  logic             doPush, doPop;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign count  = cnt;
  assign head   = empty ? '0 : mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_regif_dp.sv
module uart_regif_dp
  import uart_regif_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int LOW_LEVEL = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic [NUM_SRC-1:0] wrBits,
  output regView_t          view,
  output logic              irq,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  input  logic              txTake,
  input  logic              txShiftBusy,
  input  logic              rxStrobe,
  input  logic [BYTE_W-1:0] rxByte,
  output logic [$clog2(DEPTH+1)-1:0] rxCount,
  output logic [$clog2(DEPTH+1)-1:0] txCount
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0]  rxHead;
  logic               rxEmpty, rxFull, txEmpty, txFull;
  logic               rxEmptyQ, txLowQ, txLow;
  logic               hostEn;
  logic [NUM_SRC-1:0] intStat, intEn, setVec, clrVec;

  uart_regif_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) rxQ (
    .clk(clk), .rstN(rstN),
    .push(rxStrobe), .pushData(rxByte),
    .pop(strb.popRx),
    .head(rxHead), .empty(rxEmpty), .full(rxFull), .count(rxCount)
  );

  uart_regif_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) txQ (
    .clk(clk), .rstN(rstN),
    .push(strb.pushTx), .pushData(wrByte),
    .pop(txTake),
    .head(txByte), .empty(txEmpty), .full(txFull), .count(txCount)
  );

  assign txValid = !txEmpty;
  assign txLow   = (txCount <= CNT_W'(LOW_LEVEL));

  // event detection: edges of queue conditions
  always_comb begin
    setVec            = '0;
    setVec[SRC_RX]    = !rxEmpty && rxEmptyQ;
    setVec[SRC_TXLOW] = txLow && !txLowQ;
    setVec[SRC_OVR]   = rxStrobe && rxFull;
    clrVec            = strb.wrIntClr ? wrBits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEmptyQ <= 1'b1;
      txLowQ   <= 1'b1;
      hostEn   <= 1'b0;
      intEn    <= '0;
    end else begin
      rxEmptyQ <= rxEmpty;
      txLowQ   <= txLow;
      if (strb.wrCtrl)  hostEn <= wrBits[0];
      if (strb.wrIntEn) intEn  <= wrBits;
    end
  end

  // one sticky write-one-to-clear bit per source; a set wins over a clear
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN)          intStat[s] <= 1'b0;
      else if (setVec[s]) intStat[s] <= 1'b1;
      else if (clrVec[s]) intStat[s] <= 1'b0;
    end
  end

  assign irq = hostEn && |(intStat & intEn);

  always_comb begin
    view         = '0;
    view.rxHead  = rxHead;
    view.rxAvail = !rxEmpty;
    view.txSpace = !txFull;
    view.txBusy  = !txEmpty || txShiftBusy;
    view.hostEn  = hostEn;
    view.intStat = intStat;
    view.intEn   = intEn;
  end
endmodule

// File: rtl/uart_regif_ctrl.sv
module uart_regif_ctrl
  import uart_regif_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [BUS_W-1:0] regWrData,
  input  regView_t         view,
  output regStrobe_t       strb,
  output logic [BUS_W-1:0] regRdData
);
  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  always_comb begin
    strb          = '0;
    strb.popRx    = regWrEn && (sel == REG_DATA) && regWrData[FLAG_RX];
    strb.pushTx   = regWrEn && (sel == REG_DATA) && regWrData[FLAG_TX];
    strb.wrCtrl   = regWrEn && (sel == REG_CTRL);
    strb.wrIntClr = regWrEn && (sel == REG_STAT);
    strb.wrIntEn  = regWrEn && (sel == REG_ENABLE);
  end

  always_comb begin
    regRdData = '0;
    case (sel)
      REG_DATA: begin
        regRdData[BYTE_W-1:0] = view.rxHead;
        regRdData[FLAG_RX]    = view.rxAvail;
        regRdData[FLAG_TX]    = view.txSpace;
      end
      REG_CTRL: begin
        regRdData[0] = view.hostEn;
        regRdData[1] = view.txBusy;
      end
      REG_STAT:   regRdData[NUM_SRC-1:0] = view.intStat;
      REG_ENABLE: regRdData[NUM_SRC-1:0] = view.intEn;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int DEPTH     = 16,
  parameter int LOW_LEVEL = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  output logic              irq,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  input  logic              txTake,
  input  logic              txShiftBusy,
  input  logic              rxStrobe,
  input  logic [BYTE_W-1:0] rxByte
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  regStrobe_t       strb;
  regView_t         view;
  logic [CNT_W-1:0] rxCount, txCount;

  uart_regif_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .view(view), .strb(strb), .regRdData(regRdData)
  );

  uart_regif_dp #(.DEPTH(DEPTH), .LOW_LEVEL(LOW_LEVEL)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrByte(regWrData[BYTE_W-1:0]), .wrBits(regWrData[NUM_SRC-1:0]),
    .view(view), .irq(irq),
    .txValid(txValid), .txByte(txByte), .txTake(txTake),
    .txShiftBusy(txShiftBusy), .rxStrobe(rxStrobe), .rxByte(rxByte),
    .rxCount(rxCount), .txCount(txCount)
  );
endmodule

// File: rtl/uart_regif_checker.sv
module uart_regif_checker #(
  parameter int BUS_W = 32,
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       regAddr,
  input logic             regWrEn,
  input logic [BUS_W-1:0] regWrData,
  input logic             irq,
  input logic             txValid,
  input logic             txTake,
  input logic             txShiftBusy,
  input logic             rxStrobe,
  input logic [CNT_W-1:0] rxCount,
  input logic [CNT_W-1:0] txCount,
  input logic             hostEnQ,
  input logic [2:0]       statQ,
  input logic [2:0]       enQ,
  input logic             busyQ
);
  logic popReq, pushReq;
  assign popReq  = regWrEn && regAddr == 2'd0 && regWrData[8];
  assign pushReq = regWrEn && regAddr == 2'd0 && regWrData[9];

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    !hostEnQ |-> !irq);

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((statQ & enQ) != 3'b000));

  p_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid || txShiftBusy) |-> busyQ);

  p_depth_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount <= CNT_W'(DEPTH)) && (txCount <= CNT_W'(DEPTH)));

  p_overrun_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && rxCount == CNT_W'(DEPTH)) |=> statQ[2]);

  p_pop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && rxCount != '0 && !rxStrobe) |=> rxCount == $past(rxCount) - CNT_W'(1));

  p_full_push_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && txCount == CNT_W'(DEPTH) && !txTake) |=> txCount == CNT_W'(DEPTH));
endmodule

bind uart_regif uart_regif_checker #(.BUS_W(BUS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .irq(irq), .txValid(txValid), .txTake(txTake),
  .txShiftBusy(txShiftBusy), .rxStrobe(rxStrobe),
  .rxCount(rxCount), .txCount(txCount),
  .hostEnQ(view.hostEn), .statQ(view.intStat), .enQ(view.intEn),
  .busyQ(view.txBusy)
);

// File: tb/uart_regif_test.sv
module uart_regif_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq, txValid;
  logic [7:0]  txByte;
  logic        txTake = 1'b0;
  logic        txShiftBusy = 1'b0;
  logic        rxStrobe = 1'b0;
  logic [7:0]  rxByte = '0;

  int checks = 0;
  int failures = 0;

  uart_regif uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .txValid(txValid), .txByte(txByte), .txTake(txTake),
    .txShiftBusy(txShiftBusy), .rxStrobe(rxStrobe), .rxByte(rxByte)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic rxInject(input logic [7:0] b);
    @(negedge clk);
    rxStrobe = 1'b1; rxByte = b;
    @(negedge clk);
    rxStrobe = 1'b0;
  endtask

  task automatic txTakeOne(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, {31'b0, txValid}, 32'd1);
    check(req, {24'b0, txByte}, {24'b0, exp});
    txTake = 1'b1;
    @(negedge clk);
    txTake = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(2'd0, v); check("R13 data", v, 32'h200);
    regRead(2'd1, v); check("R13 ctrl", v, 32'h0);
    regRead(2'd2, v); check("R13 stat", v, 32'h0);
    regRead(2'd3, v); check("R13 enable", v, 32'h0);
    check("R13 irq", {31'b0, irq}, 32'd0);
  endtask

  task automatic testRxBasic();
    logic [31:0] v;
    rxInject(8'hA5);
    rxInject(8'h3C);
    regRead(2'd0, v); check("R1 head", v, 32'h3A5);
    regRead(2'd0, v); check("R1 no pop on read", v, 32'h3A5);
    regRead(2'd2, v); check("R9 rx status", v, 32'h1);
    regWrite(2'd0, 32'h100);
    regRead(2'd0, v); check("R2 pop", v, 32'h33C);
    regWrite(2'd0, 32'h100);
    regRead(2'd0, v); check("R2 empty", v, 32'h200);
    regWrite(2'd0, 32'h100);
    rxInject(8'h55);
    regRead(2'd0, v); check("R2 empty pop ignored", v, 32'h355);
    regWrite(2'd2, 32'h0);
    regRead(2'd2, v); check("R8 write zero keeps", v, 32'h1);
    regWrite(2'd2, 32'h1);
    regRead(2'd2, v); check("R8 w1c", v, 32'h0);
    regWrite(2'd0, 32'h100);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    regWrite(2'd3, 32'h1);
    rxInject(8'h77);
    regRead(2'd2, v);
    check("R6 gated", {31'b0, irq}, 32'd0);
    regWrite(2'd1, 32'h1);
    regRead(2'd1, v); check("R6 host enable reads", v, 32'h1);
    check("R7 irq on", {31'b0, irq}, 32'd1);
    regWrite(2'd3, 32'h0);
    regRead(2'd3, v);
    check("R7 disabled all", {31'b0, irq}, 32'd0);
    regWrite(2'd3, 32'h1);
    regWrite(2'd2, 32'h1);
    regRead(2'd2, v);
    check("R8 clear drops irq", {31'b0, irq}, 32'd0);
    regWrite(2'd0, 32'h100);
    regWrite(2'd3, 32'h0);
    regWrite(2'd1, 32'h0);
  endtask

  task automatic testOverrun();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) rxInject(8'h40 + 8'(i));
    regRead(2'd2, v); check("R11 no overrun at full", v & 32'h4, 32'h0);
    rxInject(8'hEE);
    regRead(2'd2, v); check("R11 overrun", v & 32'h4, 32'h4);
    for (int i = 0; i < 16; i++) begin
      regRead(2'd0, v); check("R12 rx order", v & 32'h1FF, 32'h100 | (32'h40 + i));
      regWrite(2'd0, 32'h100);
    end
    regRead(2'd0, v); check("R12 dropped byte absent", v, 32'h200);
    regWrite(2'd2, 32'h7);
  endtask

  task automatic testTx();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) regWrite(2'd0, 32'h200 | (32'h10 + i));
    regRead(2'd0, v); check("R3 full flag", v, 32'h0);
    regRead(2'd1, v); check("R5 busy", v & 32'h2, 32'h2);
    regWrite(2'd0, 32'h2EE);
    regWrite(2'd2, 32'h7);
    for (int i = 0; i < 13; i++) txTakeOne("R4 tx order", 8'h10 + 8'(i));
    regRead(2'd2, v); check("R10 not yet low", v & 32'h2, 32'h0);
    txTakeOne("R4 tx order", 8'h1D);
    regRead(2'd2, v); check("R10 low status", v & 32'h2, 32'h2);
    txTakeOne("R4 tx order", 8'h1E);
    txTakeOne("R4 tx order", 8'h1F);
    @(negedge clk);
    check("R3 full push dropped", {31'b0, txValid}, 32'd0);
    regRead(2'd0, v); check("R3 space flag", v, 32'h200);
    regRead(2'd1, v); check("R5 idle", v, 32'h0);
    txShiftBusy = 1'b1;
    regRead(2'd1, v); check("R5 shifter busy", v, 32'h2);
    txShiftBusy = 1'b0;
    regWrite(2'd2, 32'h7);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        testReset();
        testRxBasic();
        testIrq();
        testOverrun();
        testTx();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule